// File: doc/BRIEF.md
# Arithmetic Subset Instruction Decoder

This block is the decode stage for a 32-bit load/store pipeline that supports only integer add, subtract, set-on-less-than, leading-bit count and multiply instructions. Each cycle it takes one instruction word and a valid flag. It classifies the word into one of three encoding groups: register-register with primary opcode zero, the secondary arithmetic group, or immediate. It then registers a control bundle for the execute stage. The bundle holds an 8-bit operation code, a 3-bit result-class select, two source-register read enables with their addresses, a destination write enable with its address, a separate product-register write flag, and a 32-bit immediate.

Words the block does not recognise, words with a nonzero shift field in the register-register add/subtract/compare group, and cycles with the valid flag low all load an all-zero bubble. A bubble writes nothing. The block has no operand path: register reads, forwarding and hazard handling are done elsewhere.

Top module: `arith_decoder`

## Requirements
- R1: A synchronous reset, or a cycle with `in_valid` low, loads an all-zero bundle at the next rising edge, with both write enables at 0.
- R2: Every output is registered: a word presented before a rising edge appears at the outputs just after that edge and holds until the next edge.
- R3: With opcode bits [31:26]=000000 and shift bits [10:6]=00000, function bits [5:0] of 100000, 100001, 100010, 100011, 101010 and 101011 emit operation codes 0x20, 0x21, 0x22, 0x23, 0x2A and 0x2B. These words set result select 3'b100, enable both reads with addresses from bits [25:21] (port A) and [20:16] (port B), and write the register in bits [15:11].
- R4: In the R3 group, a nonzero value in bits [10:6] makes the word invalid and loads the all-zero bundle.
- R5: With opcode 000000, function 011000 gives code 0x18 and function 011001 gives code 0x19. Both enable both reads, set `hilo_wr`=1, `wr_en`=0, `wr_addr`=0 and result select 3'b000.
- R6: With opcode 011100, function 100000 gives code 0xB0 and function 100001 gives code 0xB1. Both read only port A (bits [25:21]), write the register in bits [15:11], and set result select 3'b100.
- R7: With opcode 011100 and function 000010, the word emits code 0xA9 with result select 3'b101. It enables both reads and writes the register in bits [15:11].
- R8: Opcodes 001000, 001001, 001010 and 001011 emit codes 0x55, 0x56, 0x57 and 0x58. They read only port A (bits [25:21]), write the register in bits [20:16], set result select 3'b100, and output bits [15:0] sign-extended to 32 bits as `imm`.
- R9: Any other opcode, or an unlisted function code under opcode 000000 or 011100, loads the all-zero bundle.
- R10: A disabled read port shows address 0, and `imm` is 0 for every word outside the R8 group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| alu_op | output | 8 | Execute operation code |
| res_sel | output | 3 | Result-class select |
| rd_en_a | output | 1 | First source read enable |
| rd_addr_a | output | 5 | First source register address |
| rd_en_b | output | 1 | Second source read enable |
| rd_addr_b | output | 5 | Second source register address |
| wr_en | output | 1 | Destination register write enable |
| wr_addr | output | 5 | Destination register address |
| hilo_wr | output | 1 | Product register pair write enable |
| imm | output | 32 | Sign-extended immediate operand |

## Verification
The block holds one cycle of state, so a wrong decode shows at the ports exactly one edge after the word is presented, and it is replaced at the following edge. The visible faults are a wrong operation code or select, a read port enabled with the wrong field, or a destination taken from bits [20:16] instead of [15:11] (or the reverse). A bubble that still carries a write enable, or a multiply that raises both write flags, would corrupt architectural state. The directed cases therefore sample every bundle field one edge after each word, and they use distinct rs/rt/rd values so that a swapped field shows up.

// File: rtl/arith_dec_pkg.sv
package arith_dec_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int OPC_W   = 6;
    localparam int ALUOP_W = 8;
    localparam int SEL_W   = 3;
    localparam int IMM_W   = 16;
    localparam int SH_W    = 5;

    // primary opcodes
    localparam logic [OPC_W-1:0] OPC_REGREG = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_SECOND = 6'b011100;
    localparam logic [OPC_W-1:0] OPC_ADDI   = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_SLTI   = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_SLTIU  = 6'b001011;

    // function codes, register-register group
    localparam logic [OPC_W-1:0] FN_ADD   = 6'b100000;
    localparam logic [OPC_W-1:0] FN_ADDU  = 6'b100001;
    localparam logic [OPC_W-1:0] FN_SUB   = 6'b100010;
    localparam logic [OPC_W-1:0] FN_SUBU  = 6'b100011;
    localparam logic [OPC_W-1:0] FN_SLT   = 6'b101010;
    localparam logic [OPC_W-1:0] FN_SLTU  = 6'b101011;
    localparam logic [OPC_W-1:0] FN_MULT  = 6'b011000;
    localparam logic [OPC_W-1:0] FN_MULTU = 6'b011001;

    // function codes, secondary group
    localparam logic [OPC_W-1:0] FN_CLZ = 6'b100000;
    localparam logic [OPC_W-1:0] FN_CLO = 6'b100001;
    localparam logic [OPC_W-1:0] FN_MUL = 6'b000010;

    // emitted operation codes
    localparam logic [ALUOP_W-1:0] OP_ADD   = 8'h20;
    localparam logic [ALUOP_W-1:0] OP_ADDU  = 8'h21;
    localparam logic [ALUOP_W-1:0] OP_SUB   = 8'h22;
    localparam logic [ALUOP_W-1:0] OP_SUBU  = 8'h23;
    localparam logic [ALUOP_W-1:0] OP_SLT   = 8'h2A;
    localparam logic [ALUOP_W-1:0] OP_SLTU  = 8'h2B;
    localparam logic [ALUOP_W-1:0] OP_ADDI  = 8'h55;
    localparam logic [ALUOP_W-1:0] OP_ADDIU = 8'h56;
    localparam logic [ALUOP_W-1:0] OP_SLTI  = 8'h57;
    localparam logic [ALUOP_W-1:0] OP_SLTIU = 8'h58;
    localparam logic [ALUOP_W-1:0] OP_CLZ   = 8'hB0;
    localparam logic [ALUOP_W-1:0] OP_CLO   = 8'hB1;
    localparam logic [ALUOP_W-1:0] OP_MULT  = 8'h18;
    localparam logic [ALUOP_W-1:0] OP_MULTU = 8'h19;
    localparam logic [ALUOP_W-1:0] OP_MUL   = 8'hA9;

    // result classes
    localparam logic [SEL_W-1:0] SEL_NONE  = 3'b000;
    localparam logic [SEL_W-1:0] SEL_ARITH = 3'b100;
    localparam logic [SEL_W-1:0] SEL_MUL   = 3'b101;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic [SEL_W-1:0]   res_sel;
        logic               ra_en;
        logic [REG_AW-1:0]  ra;
        logic               rb_en;
        logic [REG_AW-1:0]  rb;
        logic               we;
        logic [REG_AW-1:0]  wa;
        logic               hilo_we;
        logic [XLEN-1:0]    imm;
    } dec_bundle_t;

    // field extractors
    function automatic logic [REG_AW-1:0] fld_rs(input logic [XLEN-1:0] w);
        return w[25:21];
    endfunction

    function automatic logic [REG_AW-1:0] fld_rt(input logic [XLEN-1:0] w);
        return w[20:16];
    endfunction

    function automatic logic [REG_AW-1:0] fld_rd(input logic [XLEN-1:0] w);
        return w[15:11];
    endfunction

endpackage

// File: rtl/ad_regreg_dec.sv
module ad_regreg_dec
    import arith_dec_pkg::*;
#(
    parameter bit STRICT_SHAMT = 1'b1
) (
    input  logic [XLEN-1:0] instr,
    output logic            hit,
    output dec_bundle_t     bundle
);

    logic                 shamt_ok;
    logic [OPC_W-1:0]     fn;
    logic [ALUOP_W-1:0]   code;
    logic                 is_arith;
    logic                 is_prod;

    assign fn = instr[OPC_W-1:0];

    generate
        if (STRICT_SHAMT) begin : g_strict
            assign shamt_ok = (instr[10:6] == '0);
        end else begin : g_loose
            assign shamt_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        code     = '0;
        is_arith = 1'b0;
        is_prod  = 1'b0;
        unique case (fn)
            FN_ADD:   begin code = OP_ADD;   is_arith = 1'b1; end
            FN_ADDU:  begin code = OP_ADDU;  is_arith = 1'b1; end
            FN_SUB:   begin code = OP_SUB;   is_arith = 1'b1; end
            FN_SUBU:  begin code = OP_SUBU;  is_arith = 1'b1; end
            FN_SLT:   begin code = OP_SLT;   is_arith = 1'b1; end
            FN_SLTU:  begin code = OP_SLTU;  is_arith = 1'b1; end
            FN_MULT:  begin code = OP_MULT;  is_prod  = 1'b1; end
            FN_MULTU: begin code = OP_MULTU; is_prod  = 1'b1; end
            default:  ;
        endcase
    end

    always_comb begin
        bundle = '0;
        hit    = 1'b0;
        if (instr[31:26] == OPC_REGREG) begin
            if (is_arith && shamt_ok) begin
                hit            = 1'b1;
                bundle.alu_op  = code;
                bundle.res_sel = SEL_ARITH;
                bundle.ra_en   = 1'b1;
                bundle.ra      = fld_rs(instr);
                bundle.rb_en   = 1'b1;
                bundle.rb      = fld_rt(instr);
                bundle.we      = 1'b1;
                bundle.wa      = fld_rd(instr);
            end else if (is_prod) begin
                hit            = 1'b1;
                bundle.alu_op  = code;
                bundle.res_sel = SEL_NONE;
                bundle.ra_en   = 1'b1;
                bundle.ra      = fld_rs(instr);
                bundle.rb_en   = 1'b1;
                bundle.rb      = fld_rt(instr);
                bundle.hilo_we = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ad_second_dec.sv
module ad_second_dec
    import arith_dec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output logic            hit,
    output dec_bundle_t     bundle
);

    logic [OPC_W-1:0] fn;
    assign fn = instr[OPC_W-1:0];

    always_comb begin
        bundle = '0;
        hit    = 1'b0;
        if (instr[31:26] == OPC_SECOND) begin
            unique case (fn)
                FN_CLZ, FN_CLO: begin
                    hit            = 1'b1;
                    bundle.alu_op  = (fn == FN_CLZ) ? OP_CLZ : OP_CLO;
                    bundle.res_sel = SEL_ARITH;
                    bundle.ra_en   = 1'b1;
                    bundle.ra      = fld_rs(instr);
                    bundle.we      = 1'b1;
                    bundle.wa      = fld_rd(instr);
                end
                FN_MUL: begin
                    hit            = 1'b1;
                    bundle.alu_op  = OP_MUL;
                    bundle.res_sel = SEL_MUL;
                    bundle.ra_en   = 1'b1;
                    bundle.ra      = fld_rs(instr);
                    bundle.rb_en   = 1'b1;
                    bundle.rb      = fld_rt(instr);
                    bundle.we      = 1'b1;
                    bundle.wa      = fld_rd(instr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ad_imm_dec.sv
module ad_imm_dec
    import arith_dec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output logic            hit,
    output dec_bundle_t     bundle
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [ALUOP_W-1:0] code;
    logic               known;
    logic [XLEN-1:0]    sext;

    assign sext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    always_comb begin
        code  = '0;
        known = 1'b1;
        unique case (instr[31:26])
            OPC_ADDI:  code = OP_ADDI;
            OPC_ADDIU: code = OP_ADDIU;
            OPC_SLTI:  code = OP_SLTI;
            OPC_SLTIU: code = OP_SLTIU;
            default:   known = 1'b0;
        endcase
    end

    always_comb begin
        bundle = '0;
        hit    = known;
        if (known) begin
            bundle.alu_op  = code;
            bundle.res_sel = SEL_ARITH;
            bundle.ra_en   = 1'b1;
            bundle.ra      = fld_rs(instr);
            bundle.we      = 1'b1;
            bundle.wa      = fld_rt(instr);
            bundle.imm     = sext;
        end
    end

endmodule

// File: rtl/arith_decoder.sv
module arith_decoder
    import arith_dec_pkg::*;
#(
    parameter bit STRICT_SHAMT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [XLEN-1:0]      instr,
    output logic [ALUOP_W-1:0]   alu_op,
    output logic [SEL_W-1:0]     res_sel,
    output logic                 rd_en_a,
    output logic [REG_AW-1:0]    rd_addr_a,
    output logic                 rd_en_b,
    output logic [REG_AW-1:0]    rd_addr_b,
    output logic                 wr_en,
    output logic [REG_AW-1:0]    wr_addr,
    output logic                 hilo_wr,
    output logic [XLEN-1:0]      imm
);

    localparam int N_GRP = 3;

    dec_bundle_t grp_bundle [N_GRP];
    logic [N_GRP-1:0] grp_hit;

    dec_bundle_t dec_d;
    dec_bundle_t dec_q;

    ad_regreg_dec #(.STRICT_SHAMT(STRICT_SHAMT)) u_regreg (
        .instr  (instr),
        .hit    (grp_hit[0]),
        .bundle (grp_bundle[0])
    );

    ad_second_dec u_second (
        .instr  (instr),
        .hit    (grp_hit[1]),
        .bundle (grp_bundle[1])
    );

    ad_imm_dec u_imm (
        .instr  (instr),
        .hit    (grp_hit[2]),
        .bundle (grp_bundle[2])
    );

    // groups are opcode-exclusive; the first hit wins
    always_comb begin
        dec_d = '0;
        if (in_valid) begin
            for (int g = N_GRP - 1; g >= 0; g--) begin
                if (grp_hit[g]) begin
                    dec_d = grp_bundle[g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign alu_op    = dec_q.alu_op;
    assign res_sel   = dec_q.res_sel;
    assign rd_en_a   = dec_q.ra_en;
    assign rd_addr_a = dec_q.ra;
    assign rd_en_b   = dec_q.rb_en;
    assign rd_addr_b = dec_q.rb;
    assign wr_en     = dec_q.we;
    assign wr_addr   = dec_q.wa;
    assign hilo_wr   = dec_q.hilo_we;
    assign imm       = dec_q.imm;

endmodule

// File: rtl/arith_decoder_chk.sv
module arith_decoder_chk
    import arith_dec_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [XLEN-1:0]      instr,
    input logic [ALUOP_W-1:0]   alu_op,
    input logic [SEL_W-1:0]     res_sel,
    input logic                 rd_en_a,
    input logic [REG_AW-1:0]    rd_addr_a,
    input logic                 rd_en_b,
    input logic [REG_AW-1:0]    rd_addr_b,
    input logic                 wr_en,
    input logic [REG_AW-1:0]    wr_addr,
    input logic                 hilo_wr,
    input logic [XLEN-1:0]      imm
);

    AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (alu_op == '0 && !wr_en && !hilo_wr && !rd_en_a && !rd_en_b && imm == '0)); // R1

    AST_ADD_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:26] == OPC_REGREG && instr[5:0] == FN_ADD && instr[10:6] == '0)
        |=> (alu_op == OP_ADD && wr_en && wr_addr == $past(instr[15:11]))); // R2

    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hilo_wr)); // R5

    AST_HILO_SHAPE: assert property (@(posedge clk) disable iff (rst)
        hilo_wr |-> ((alu_op == OP_MULT || alu_op == OP_MULTU) && rd_en_a && rd_en_b
                     && res_sel == SEL_NONE && wr_addr == '0)); // R5

    AST_MUL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (alu_op == OP_MUL) |-> (res_sel == SEL_MUL && wr_en && rd_en_a && rd_en_b)); // R7

    AST_PORTB_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en_b |-> (rd_addr_b == '0)); // R10

    AST_PORTA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en_a |-> (rd_addr_a == '0 && alu_op == '0)); // R10

    AST_IMM_GROUP: assert property (@(posedge clk) disable iff (rst)
        (imm != '0) |-> (rd_en_a && !rd_en_b && wr_en && alu_op >= OP_ADDI && alu_op <= OP_SLTIU)); // R8

endmodule

bind arith_decoder arith_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .alu_op    (alu_op),
    .res_sel   (res_sel),
    .rd_en_a   (rd_en_a),
    .rd_addr_a (rd_addr_a),
    .rd_en_b   (rd_en_b),
    .rd_addr_b (rd_addr_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .hilo_wr   (hilo_wr),
    .imm       (imm)
);

// File: tb/sim_arith_decoder.sv
`timescale 1ns/1ps
module sim_arith_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [7:0]  alu_op;
    logic [2:0]  res_sel;
    logic        rd_en_a;
    logic [4:0]  rd_addr_a;
    logic        rd_en_b;
    logic [4:0]  rd_addr_b;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic        hilo_wr;
    logic [31:0] imm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    arith_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .alu_op(alu_op), .res_sel(res_sel),
        .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .hilo_wr(hilo_wr), .imm(imm)
    );

    function automatic logic [31:0] mk_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] mk_s(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b011100, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] k);
        return {op, rs, rt, k};
    endfunction

    function automatic logic [61:0] pack(input logic [7:0] a, input logic [2:0] s,
                                         input logic ea, input logic [4:0] ra,
                                         input logic eb, input logic [4:0] rb,
                                         input logic we, input logic [4:0] wa,
                                         input logic hw, input logic [31:0] k);
        return {a, s, ea, ra, eb, rb, we, wa, hw, k};
    endfunction

    task automatic check(input string tag, input logic [61:0] exp);
        logic [61:0] act;
        act = pack(alu_op, res_sel, rd_en_a, rd_addr_a, rd_en_b, rd_addr_b,
                   wr_en, wr_addr, hilo_wr, imm);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] w);
        @(negedge clk);
        in_valid = v;
        instr    = w;
        @(posedge clk);
        #1;
    endtask

    localparam logic [61:0] ZERO = '0;

    task automatic t_reset();
        rst = 1'b1;
        issue(1'b1, mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100000));
        check("R1 reset", ZERO);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_regreg();
        logic [5:0] fns [6] = '{6'b100000, 6'b100001, 6'b100010, 6'b100011, 6'b101010, 6'b101011};
        logic [7:0] ops [6] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h2A, 8'h2B};
        for (int i = 0; i < 6; i++) begin
            logic [4:0] rs = 5'(i + 1);
            logic [4:0] rt = 5'(i + 9);
            logic [4:0] rd = 5'(31 - i);
            issue(1'b1, mk_r(rs, rt, rd, 5'd0, fns[i]));
            check("R3 regreg", pack(ops[i], 3'b100, 1'b1, rs, 1'b1, rt, 1'b1, rd, 1'b0, 32'h0));
        end
    endtask

    task automatic t_shamt();
        issue(1'b1, mk_r(5'd4, 5'd5, 5'd6, 5'd7, 6'b100010));
        check("R4 shift field set", ZERO);
        issue(1'b1, mk_r(5'd4, 5'd5, 5'd6, 5'd1, 6'b101011));
        check("R4 shift field one", ZERO);
    endtask

    task automatic t_mult();
        issue(1'b1, mk_r(5'd7, 5'd8, 5'd0, 5'd0, 6'b011000));
        check("R5 signed product", pack(8'h18, 3'b000, 1'b1, 5'd7, 1'b1, 5'd8, 1'b0, 5'd0, 1'b1, 32'h0));
        issue(1'b1, mk_r(5'd30, 5'd2, 5'd0, 5'd0, 6'b011001));
        check("R5 unsigned product", pack(8'h19, 3'b000, 1'b1, 5'd30, 1'b1, 5'd2, 1'b0, 5'd0, 1'b1, 32'h0));
    endtask

    task automatic t_second();
        issue(1'b1, mk_s(5'd11, 5'd12, 5'd13, 6'b100000));
        check("R6 R10 leading zeros", pack(8'hB0, 3'b100, 1'b1, 5'd11, 1'b0, 5'd0, 1'b1, 5'd13, 1'b0, 32'h0));
        issue(1'b1, mk_s(5'd14, 5'd15, 5'd16, 6'b100001));
        check("R6 R10 leading ones", pack(8'hB1, 3'b100, 1'b1, 5'd14, 1'b0, 5'd0, 1'b1, 5'd16, 1'b0, 32'h0));
        issue(1'b1, mk_s(5'd17, 5'd18, 5'd19, 6'b000010));
        check("R7 low product", pack(8'hA9, 3'b101, 1'b1, 5'd17, 1'b1, 5'd18, 1'b1, 5'd19, 1'b0, 32'h0));
    endtask

    task automatic t_imm();
        issue(1'b1, mk_i(6'b001000, 5'd3, 5'd4, 16'h8001));
        check("R8 add imm negative", pack(8'h55, 3'b100, 1'b1, 5'd3, 1'b0, 5'd0, 1'b1, 5'd4, 1'b0, 32'hFFFF_8001));
        issue(1'b1, mk_i(6'b001001, 5'd5, 5'd6, 16'h7FFF));
        check("R8 add imm positive", pack(8'h56, 3'b100, 1'b1, 5'd5, 1'b0, 5'd0, 1'b1, 5'd6, 1'b0, 32'h0000_7FFF));
        issue(1'b1, mk_i(6'b001010, 5'd21, 5'd22, 16'hFFFF));
        check("R8 compare imm", pack(8'h57, 3'b100, 1'b1, 5'd21, 1'b0, 5'd0, 1'b1, 5'd22, 1'b0, 32'hFFFF_FFFF));
        issue(1'b1, mk_i(6'b001011, 5'd23, 5'd24, 16'h0000));
        check("R8 compare imm unsigned", pack(8'h58, 3'b100, 1'b1, 5'd23, 1'b0, 5'd0, 1'b1, 5'd24, 1'b0, 32'h0));
    endtask

    task automatic t_invalid();
        issue(1'b1, mk_i(6'b000010, 5'd1, 5'd2, 16'h1234));
        check("R9 unknown opcode", ZERO);
        issue(1'b1, mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b001000));
        check("R9 unknown regreg function", ZERO);
        issue(1'b1, mk_s(5'd1, 5'd2, 5'd3, 6'b000011));
        check("R9 unknown secondary function", ZERO);
    endtask

    task automatic t_bubble();
        issue(1'b1, mk_i(6'b001000, 5'd9, 5'd10, 16'h0042));
        issue(1'b0, mk_i(6'b001000, 5'd9, 5'd10, 16'h0042));
        check("R1 valid low", ZERO);
        issue(1'b0, mk_r(5'd1, 5'd2, 5'd0, 5'd0, 6'b011000));
        check("R1 valid low product", ZERO);
    endtask

    task automatic t_latency();
        issue(1'b1, mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100000));
        @(negedge clk);
        in_valid = 1'b1;
        instr    = mk_r(5'd4, 5'd5, 5'd6, 5'd0, 6'b100010);
        #1;
        check("R2 holds before edge", pack(8'h20, 3'b100, 1'b1, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b0, 32'h0));
        @(posedge clk);
        #1;
        check("R2 updates after edge", pack(8'h22, 3'b100, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 5'd6, 1'b0, 32'h0));
    endtask

    initial begin
        t_reset();
        t_regreg();
        t_shamt();
        t_mult();
        t_second();
        t_imm();
        t_invalid();
        t_bubble();
        t_latency();
        rst = 1'b1;
        issue(1'b1, mk_s(5'd1, 5'd2, 5'd3, 6'b000010));
        check("R1 reset mid-run", ZERO);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule